// File: doc/BRIEF.md
# Multiplexed-Bus Opcode Fetch Sequencer

This block steps a processor bus interface through the clock states of one opcode fetch on a bus where the low address byte and the data byte share eight lines. It holds a program counter. On a start request it puts the counter on the bus under an address strobe, then releases the shared lines and pulls an active-low read strobe. It stretches the read while a device holds its ready line low, and captures the returned byte into an instruction register. A fourth internal state follows, used for decode. After that the counter advances by one.

A transparent latch sits alongside the sequencer. It rebuilds the low address byte from the shared lines while the address strobe is high, and it keeps that byte once the strobe falls. An external bus master may request the bus. The request is granted only between fetches, and every bus output is released while the grant lasts. Write cycles and instruction execution are outside this block.

Top module: `opfetch_seq`

## Requirements
- R1: While `rst_n` is low, `bus_oe` and `ad_oe` are 0, `rd_n` is 1, and `ale`, `hlda` and `done` are 0. After reset the program counter `pc_q` is 0.
- R2: In the address state (T1), `ale` is 1, `ad_oe` is 1, `addr_hi` equals `pc_q[15:8]` and `ad_out` equals `pc_q[7:0]`. T1 follows one clock after `start` is seen in idle.
- R3: `io_m` is 0 whenever the bus is driven, which marks every fetch as a memory access. The value 1 would mean I/O.
- R4: `rd_n` is 0 during T2 and T3, and `ad_oe` is 0 whenever `rd_n` is 0. With `ready` high, `rd_n` is low for exactly two clocks, starting in the cycle right after T1.
- R5: `ready` is sampled only at the clock edge that ends T2 and at the edge that ends each wait state. Each low sample adds one wait clock with `rd_n` held low. `ready` has no effect in any other state.
- R6: `ir` takes the value of `ad_in` at the edge that ends T3. In T4, `rd_n` is 1, `ad_oe` is 0 and `done` is 1.
- R7: `lo_addr` follows the shared lines while `ale` is 1. From T2 onward it holds the low byte of the fetched address.
- R8: `hold` is granted only in idle or at the end of T4. `hlda` stays 1 until `hold` drops, and while `hlda` is 1, `bus_oe` and `ad_oe` are 0.
- R9: `pc_q` increments by one, wrapping from 16'hFFFF to 0, at the edge that ends T4. `pc_ld` loads `pc_din` only in idle and is ignored during a fetch.
- R10: `start` is ignored while the bus is granted. No T1 occurs until `hlda` has dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Fetch request, sampled in idle and at the end of T4 |
| pc_ld | input | 1 | Load strobe for the program counter (idle only) |
| pc_din | input | 16 | Value to load into the program counter |
| ready | input | 1 | Device ready; low stretches the read |
| hold | input | 1 | External bus request |
| ad_in | input | 8 | Shared lines as seen from the bus |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Value driven on the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| bus_oe | output | 1 | Output enable for the high address, strobe and status lines |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| io_m | output | 1 | I/O-versus-memory status (0 = memory) |
| hlda | output | 1 | Bus grant |
| ir | output | 8 | Instruction register |
| done | output | 1 | High in T4 of each fetch |
| pc_q | output | 16 | Program counter |
| lo_addr | output | 8 | Low address byte rebuilt by the latch |

## Verification
Some relations hold on every cycle, and the assertions check these. A grant keeps both output enables off and persists while the request stays high. The read strobe never coincides with the shared lines being driven. Every T1 leads straight into a read, and the strobe rises only in T4. The counter also steps by one after every T4.

Other behaviour can only be shown by the bench's scenarios. It counts the read-strobe length against a chosen number of low ready samples. It checks that ready is ignored in T3, that the captured opcode matches the modelled memory at the rebuilt address, and that loads and starts are ignored at the wrong times. It also checks that a request raised mid-fetch waits until T4 has ended, and that the counter wraps at the top of the address space.

// File: rtl/opfetch_seq.sv
module opfetch_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pc_ld,
  input  logic [AW-1:0] pc_din,
  input  logic          ready,
  input  logic          hold,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          bus_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          io_m,
  output logic          hlda,
  output logic [DW-1:0] ir,
  output logic          done,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] lo_addr
);

  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4, S_HOLD
  } st_t;

  st_t st, st_nx;
  logic [DW-1:0] bus_val;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (hold) st_nx = S_HOLD;
              else if (!pc_ld && start) st_nx = S_T1;
      S_T1:   st_nx = S_T2;
      S_T2:   st_nx = ready ? S_T3 : S_TW;
      S_TW:   st_nx = ready ? S_T3 : S_TW;
      S_T3:   st_nx = S_T4;
      S_T4:   if (hold) st_nx = S_HOLD;
              else if (start) st_nx = S_T1;
              else st_nx = S_IDLE;
      S_HOLD: if (!hold) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pc_q <= '0;
      ir   <= '0;
    end else begin
      st <= st_nx;
      if (st == S_IDLE && !hold && pc_ld) pc_q <= pc_din;
      if (st == S_T4) pc_q <= pc_q + 1'b1;
      if (st == S_T3) ir <= ad_in;
    end
  end

  assign bus_oe  = rst_n && (st != S_HOLD);
  assign ad_oe   = rst_n && (st == S_T1);
  assign ale     = (st == S_T1);
  assign rd_n    = !(st == S_T2 || st == S_TW || st == S_T3);
  assign io_m    = 1'b0;
  assign hlda    = (st == S_HOLD);
  assign done    = (st == S_T4);
  assign addr_hi = pc_q[AW-1:DW];
  assign ad_out  = pc_q[DW-1:0];
  assign bus_val = ad_oe ? ad_out : ad_in;

  always_latch begin
    if (ale) lo_addr = bus_val;
  end

endmodule

module opfetch_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale,
  input logic          rd_n,
  input logic          ad_oe,
  input logic          bus_oe,
  input logic          hlda,
  input logic          hold,
  input logic          done,
  input logic [AW-1:0] pc_q
);

  // R8
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!bus_oe && !ad_oe));

  // R8
  grant_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && hold) |=> hlda);

  // R4
  read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R4
  addr_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !rd_n);

  // R6
  read_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n ##1 rd_n) |-> done);

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (pc_q == $past(pc_q) + 1'b1));

endmodule

bind opfetch_seq opfetch_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .ad_oe(ad_oe),
  .bus_oe(bus_oe), .hlda(hlda), .hold(hold), .done(done), .pc_q(pc_q)
);

// File: tb/sim_opfetch_seq.sv
module sim_opfetch_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pc_ld = 1'b0, ready = 1'b1, hold = 1'b0;
  logic [15:0] pc_din = '0;
  logic [7:0] ad_in;
  logic [7:0] addr_hi, ad_out, ir, lo_addr;
  logic ad_oe, bus_oe, ale, rd_n, io_m, hlda, done;
  logic [15:0] pc_q;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [15:0] exp_pc = '0;

  always #2 clk = ~clk;

  opfetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_ld(pc_ld), .pc_din(pc_din),
    .ready(ready), .hold(hold), .ad_in(ad_in), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .bus_oe(bus_oe), .ale(ale), .rd_n(rd_n),
    .io_m(io_m), .hlda(hlda), .ir(ir), .done(done), .pc_q(pc_q),
    .lo_addr(lo_addr)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign ad_in = rd_n ? 8'h00 : memf({addr_hi, lo_addr});

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fetch(input int w, input bit hl, input bit junk);
    start = 1'b1;
    tick();
    check("R2 ale", {15'd0, ale}, 16'd1);
    check("R2 ad_oe", {15'd0, ad_oe}, 16'd1);
    check("R2 addr", {addr_hi, ad_out}, exp_pc);
    check("R3 io_m", {15'd0, io_m}, 16'd0);
    check("R7 latch open", {8'd0, lo_addr}, {8'd0, exp_pc[7:0]});
    start = 1'b0;
    ready = (w == 0);
    tick();
    check("R4 T2 rd_n", {15'd0, rd_n}, 16'd0);
    check("R4 T2 float", {15'd0, ad_oe}, 16'd0);
    check("R7 latch hold", {8'd0, lo_addr}, {8'd0, exp_pc[7:0]});
    if (junk) begin pc_ld = 1'b1; pc_din = ~exp_pc; end
    if (hl) hold = 1'b1;
    for (int i = 0; i < w; i++) begin
      tick();
      pc_ld = 1'b0;
      check("R5 wait rd_n", {15'd0, rd_n}, 16'd0);
      check("R8 no early grant", {15'd0, hlda}, 16'd0);
      ready = (i + 1 == w);
    end
    tick();
    pc_ld = 1'b0;
    check("R4 T3 rd_n", {15'd0, rd_n}, 16'd0);
    check("R8 no grant T3", {15'd0, hlda}, 16'd0);
    ready = 1'b0;
    tick();
    check("R6 T4 rd_n", {15'd0, rd_n}, 16'd1);
    check("R5 ready ignored in T3", {15'd0, done}, 16'd1);
    check("R6 T4 float", {15'd0, ad_oe}, 16'd0);
    check("R6 ir", {8'd0, ir}, {8'd0, memf(exp_pc)});
    check("R8 bus kept T4", {15'd0, bus_oe}, 16'd1);
    ready = 1'b1;
    tick();
    exp_pc = exp_pc + 16'd1;
    check("R9 pc step", pc_q, exp_pc);
    if (hl) begin
      check("R8 grant", {15'd0, hlda}, 16'd1);
      check("R8 released", {14'd0, bus_oe, ad_oe}, 16'd0);
      start = 1'b1;
      tick();
      check("R10 start ignored", {15'd0, ale}, 16'd0);
      check("R8 grant held", {15'd0, hlda}, 16'd1);
      start = 1'b0;
      hold = 1'b0;
      tick();
      check("R8 grant dropped", {15'd0, hlda}, 16'd0);
      check("R8 bus back", {15'd0, bus_oe}, 16'd1);
    end else begin
      check("R8 idle no grant", {15'd0, hlda}, 16'd0);
    end
  endtask

  task automatic load(input logic [15:0] v);
    pc_ld = 1'b1;
    pc_din = v;
    tick();
    pc_ld = 1'b0;
    exp_pc = v;
    check("R9 load", pc_q, v);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) tick();
    check("R1 bus_oe", {15'd0, bus_oe}, 16'd0);
    check("R1 ad_oe", {15'd0, ad_oe}, 16'd0);
    check("R1 rd_n", {15'd0, rd_n}, 16'd1);
    check("R1 ale/hlda/done", {13'd0, ale, hlda, done}, 16'd0);
    rst_n = 1'b1;
    tick();
    check("R1 pc", pc_q, 16'd0);
    check("R1 bus after", {15'd0, bus_oe}, 16'd1);

    fetch(0, 1'b0, 1'b0);
    fetch(2, 1'b0, 1'b1);
    load(16'hFFFF);
    fetch(1, 1'b0, 1'b0);
    check("R9 wrap", pc_q, 16'h0000);
    load(16'h2005);
    fetch(0, 1'b1, 1'b0);

    hold = 1'b1;
    start = 1'b1;
    tick();
    check("R8 idle grant", {15'd0, hlda}, 16'd1);
    check("R10 no T1", {15'd0, ale}, 16'd0);
    check("R8 idle release", {14'd0, bus_oe, ad_oe}, 16'd0);
    start = 1'b0;
    hold = 1'b0;
    tick();
    check("R8 idle drop", {15'd0, hlda}, 16'd0);
    check("R10 pc kept", pc_q, exp_pc);

    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(0, 2) == 0) load(16'($urandom()));
      fetch(int'($urandom_range(0, 3)), bit'($urandom_range(0, 3) == 0),
            bit'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule